// File: doc/BRIEF.md
# Biphase Teletext-Free Line Data Decoder

This block recovers one programme-control data line from a sliced, oversampled bit stream. A line gate marks the sampling window of the selected blanking line (the gate is raised only on the dedicated lines 16 and 329 by the surrounding timing logic). The first sample with the gate high is the start of the first bit cell. Each bit occupies a fixed number of samples and is biphase coded. The decoder reads the middle of each half-cell, assembles 15 eight-bit words, and checks the first two words against synchronisation patterns.

A complete, error-free line with matching synchronisation words is published in one step. The block presents the full 120-bit word image, the two-bit sound identification field from word 5, and the 10-bit country/network identifier. The identifier is made from the low two bits of word 13 and all of word 14. Its upper four bits form the country part and its lower six bits the network part. A single-cycle strobe marks each new result. A flag reports a biphase violation seen in the current line.

Top module: `vps_line_decoder`

## Requirements
- R1: After a synchronous active-low reset, `valid_o` and `bphase_err_o` are 0, and `words_o`, `sound_o` and `cni_o` are all zero.
- R2: Sample 0 is the first cycle with `line_en` high, and bit n spans samples 8n to 8n+7. The bit value is the sample at offset 2 of its cell: a first half high and a second half low is a 1, and the reverse is a 0. Bits arrive most significant first. Word k (1..15) appears in `words_o[127-8k -: 8]`, so word 1 sits in bits [119:112].
- R3: `sound_o` equals bits [7:6] of word 5.
- R4: `cni_o` equals {word13[1:0], word14[7:0]}. The country part is `cni_o[9:6]` and the network part is `cni_o[5:0]`.
- R5: If word 1 differs from `SYNC_W1` or word 2 differs from `SYNC_W2`, the line is discarded. No strobe is given and all outputs hold their previous values.
- R6: A bit whose samples at offsets 2 and 6 are equal is a biphase error. It sets `bphase_err_o`, and the line is then discarded with no strobe and no output change.
- R7: `bphase_err_o` is cleared by the next rising edge of `line_en`, and stays clear through a clean line.
- R8: A clean line with matching synchronisation words gives exactly one single-cycle `valid_o` pulse. All outputs take the new line's values at that pulse.
- R9: A line whose gate falls before all 120 bits have arrived is discarded, and its outputs hold.
- R10: While `line_en` is low, `din` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, eight samples per data bit |
| rst_n | input | 1 | Synchronous active-low reset |
| line_en | input | 1 | Sampling window of an enabled data line |
| din | input | 1 | Sliced data sample |
| words_o | output | 120 | Word image of the last accepted line, word 1 in the top byte |
| valid_o | output | 1 | One-cycle strobe on each accepted line |
| sound_o | output | 2 | Sound identification field |
| cni_o | output | 10 | Country (bits 9:6) and network (bits 5:0) identifier |
| bphase_err_o | output | 1 | Biphase violation seen in the current line |

## Verification
The bench injects a single biphase violation at positions spread across all 120 bits, including the first and the very last bit. A decoder that samples the wrong half-cell, or that publishes before it counts the final bit's error, would strobe a corrupted line. Corrupted synchronisation words and a gate cut off mid-line must leave the previous result untouched; a design that updates outputs before qualification would show the partial data. The bench also checks that the error flag clears only at the next line start and that samples toggling outside the gate are ignored. Word positions are checked against arithmetic word contents, so a design that reverses bit order or mis-indexes words 5, 13 or 14 is caught.

// File: rtl/vps_pkg.sv
// vps_pkg: line geometry shared by the decoder modules.
// Assumes the fixed 15-word, 8-bit-per-word line layout.
package vps_pkg;
    localparam int unsigned VPS_NWORDS = 15;
    localparam int unsigned VPS_WBITS  = 8;
    localparam int unsigned VPS_NBITS  = VPS_NWORDS * VPS_WBITS;
    localparam int unsigned SOUND_WORD = 5;
    localparam int unsigned CNI_HI_WORD = 13;
    localparam int unsigned CNI_LO_WORD = 14;
    localparam int unsigned CNI_W      = 10;

    // Least significant bit index of word k (1-based) in the packed image.
    function automatic int unsigned word_lsb(input int unsigned k);
        return VPS_NBITS - VPS_WBITS * k;
    endfunction
endpackage

// File: rtl/vps_cell_slicer.sv
// vps_cell_slicer: times the bit cells of a gated line and decodes each
// biphase cell from the mid-points of its two halves.
// Assumes SPB is a multiple of 4 (at least 4). The first cycle with line_en
// high is sample 0 of bit 0.
module vps_cell_slicer #(
    parameter int unsigned SPB = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_en,
    input  logic din,
    output logic line_go,
    output logic bit_vld,
    output logic bit_val,
    output logic bit_err
);
    localparam int unsigned PW = $clog2(SPB);
    localparam int unsigned Q1 = SPB / 4;
    localparam int unsigned Q3 = SPB / 2 + SPB / 4;

    logic          en_q;
    logic          run;
    logic [PW-1:0] phase;
    logic          h1;

    // Cell timing, half-cell capture and bit decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            run     <= 1'b0;
            phase   <= '0;
            h1      <= 1'b0;
            line_go <= 1'b0;
            bit_vld <= 1'b0;
            bit_val <= 1'b0;
            bit_err <= 1'b0;
        end else begin
            en_q    <= line_en;
            line_go <= line_en && !en_q;
            bit_vld <= 1'b0;
            if (!line_en) begin
                run   <= 1'b0;
                phase <= '0;
            end else if (!en_q) begin
                run   <= 1'b1;
                phase <= PW'(1);
            end else if (run) begin
                phase <= (phase == PW'(SPB - 1)) ? '0 : phase + PW'(1);
                if (phase == PW'(Q1)) begin
                    h1 <= din;
                end
                if (phase == PW'(Q3)) begin
                    bit_vld <= 1'b1;
                    bit_val <= h1;
                    bit_err <= (h1 == din);
                end
            end
        end
    end

    // R10
    no_bit_outside_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !line_en |=> !bit_vld);
    // R2
    bit_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld |=> !bit_vld);
endmodule

// File: rtl/vps_word_asm.sv
// vps_word_asm: shifts decoded bits into the line image, counts them and
// tracks biphase errors for the current line.
// Assumes line_go precedes the first bit of every line; bits past NBITS are ignored.
module vps_word_asm #(
    parameter int unsigned NBITS = 120
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_go,
    input  logic             bit_vld,
    input  logic             bit_val,
    input  logic             bit_err,
    output logic [NBITS-1:0] line_bits,
    output logic             line_done,
    output logic             err_flag
);
    localparam int unsigned CW = $clog2(NBITS + 1);

    logic [CW-1:0] cnt;

    // Bit collection, line-complete pulse and sticky error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_bits <= '0;
            cnt       <= '0;
            line_done <= 1'b0;
            err_flag  <= 1'b0;
        end else if (line_go) begin
            cnt       <= '0;
            line_done <= 1'b0;
            err_flag  <= 1'b0;
        end else begin
            line_done <= 1'b0;
            if (bit_vld && cnt != CW'(NBITS)) begin
                line_bits <= {line_bits[NBITS-2:0], bit_val};
                cnt       <= cnt + CW'(1);
                if (bit_err) begin
                    err_flag <= 1'b1;
                end
                if (cnt == CW'(NBITS - 1)) begin
                    line_done <= 1'b1;
                end
            end
        end
    end

    // R9
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(NBITS));
    // R7
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_go |=> !err_flag);
endmodule

// File: rtl/vps_frame_check.sv
// vps_frame_check: qualifies a completed line (no biphase error, both sync
// words as expected) and publishes the word image and extracted fields.
// Assumes line_done is a single-cycle pulse with line_bits stable at that time.
module vps_frame_check
    import vps_pkg::*;
#(
    parameter logic [7:0] SYNC_W1 = 8'hA5,
    parameter logic [7:0] SYNC_W2 = 8'h3C
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 line_done,
    input  logic                 line_err,
    input  logic [VPS_NBITS-1:0] line_bits,
    output logic [VPS_NBITS-1:0] words_o,
    output logic                 valid_o,
    output logic [1:0]           sound_o,
    output logic [CNI_W-1:0]     cni_o
);
    localparam int unsigned W1_LSB  = word_lsb(1);
    localparam int unsigned W2_LSB  = word_lsb(2);
    localparam int unsigned SND_LSB = word_lsb(SOUND_WORD);
    localparam int unsigned C13_LSB = word_lsb(CNI_HI_WORD);
    localparam int unsigned C14_LSB = word_lsb(CNI_LO_WORD);

    logic sync_ok;

    // Compare both leading words against the expected patterns.
    always_comb begin
        sync_ok = (line_bits[W1_LSB +: VPS_WBITS] == SYNC_W1) &&
                  (line_bits[W2_LSB +: VPS_WBITS] == SYNC_W2);
    end

    // Publish a qualified line and raise the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            words_o <= '0;
            valid_o <= 1'b0;
            sound_o <= '0;
            cni_o   <= '0;
        end else begin
            valid_o <= 1'b0;
            if (line_done && !line_err && sync_ok) begin
                words_o <= line_bits;
                valid_o <= 1'b1;
                sound_o <= line_bits[SND_LSB + 6 +: 2];
                cni_o   <= {line_bits[C13_LSB +: 2], line_bits[C14_LSB +: VPS_WBITS]};
            end
        end
    end

    // R8
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
    // R5
    sync_words_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (words_o[W1_LSB +: VPS_WBITS] == SYNC_W1 &&
                     words_o[W2_LSB +: VPS_WBITS] == SYNC_W2));
    // R6
    clean_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> !line_err);
    // R8
    hold_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |=> (valid_o || $stable(words_o)));
endmodule

// File: rtl/vps_line_decoder.sv
// vps_line_decoder: top level of the biphase line decoder. Chains the cell
// slicer, the word assembler and the frame qualifier.
// Assumes line_en is raised only on the enabled blanking lines and is aligned
// to the first sample of the first bit cell.
module vps_line_decoder
    import vps_pkg::*;
#(
    parameter int unsigned SPB     = 8,
    parameter logic [7:0]  SYNC_W1 = 8'hA5,
    parameter logic [7:0]  SYNC_W2 = 8'h3C
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 line_en,
    input  logic                 din,
    output logic [VPS_NBITS-1:0] words_o,
    output logic                 valid_o,
    output logic [1:0]           sound_o,
    output logic [CNI_W-1:0]     cni_o,
    output logic                 bphase_err_o
);
    logic                 line_go;
    logic                 bit_vld;
    logic                 bit_val;
    logic                 bit_err;
    logic [VPS_NBITS-1:0] line_bits;
    logic                 line_done;
    logic                 err_flag;

    vps_cell_slicer #(.SPB(SPB)) u_slicer (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_en (line_en),
        .din     (din),
        .line_go (line_go),
        .bit_vld (bit_vld),
        .bit_val (bit_val),
        .bit_err (bit_err)
    );

    vps_word_asm #(.NBITS(VPS_NBITS)) u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_go   (line_go),
        .bit_vld   (bit_vld),
        .bit_val   (bit_val),
        .bit_err   (bit_err),
        .line_bits (line_bits),
        .line_done (line_done),
        .err_flag  (err_flag)
    );

    vps_frame_check #(.SYNC_W1(SYNC_W1), .SYNC_W2(SYNC_W2)) u_check (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_done (line_done),
        .line_err  (err_flag),
        .line_bits (line_bits),
        .words_o   (words_o),
        .valid_o   (valid_o),
        .sound_o   (sound_o),
        .cni_o     (cni_o)
    );

    assign bphase_err_o = err_flag;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (!valid_o && !bphase_err_o));
endmodule

// File: tb/sim_vps_line_decoder.sv
module sim_vps_line_decoder;
    localparam logic [7:0] S1 = 8'hA5;
    localparam logic [7:0] S2 = 8'h3C;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         line_en = 1'b0;
    logic         din = 1'b0;
    logic [119:0] words_o;
    logic         valid_o;
    logic [1:0]   sound_o;
    logic [9:0]   cni_o;
    logic         bphase_err_o;

    int total = 0;
    int bad = 0;
    int vcnt = 0;
    int cyc = 0;
    logic [119:0] last_good = '0;

    vps_line_decoder #(.SPB(8), .SYNC_W1(S1), .SYNC_W2(S2)) u0 (
        .clk(clk), .rst_n(rst_n), .line_en(line_en), .din(din),
        .words_o(words_o), .valid_o(valid_o), .sound_o(sound_o),
        .cni_o(cni_o), .bphase_err_o(bphase_err_o)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (valid_o) vcnt <= vcnt + 1;
    end

    initial begin
        wait (cyc >= 190000);
        bad = bad + 1;
        $display("FAIL watchdog actual=%0d expected=<190000", cyc);
        $display("test done: total=%0d bad=%0d", total + 1, bad);
        $finish;
    end

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] wval(input int seed, input int k);
        if (k == 1) return S1;
        if (k == 2) return S2;
        return 8'((seed * 29 + k * 53 + 7) & 255);
    endfunction

    function automatic logic [119:0] build(input int seed);
        logic [119:0] b;
        for (int k = 1; k <= 15; k++) b[127 - 8 * k -: 8] = wval(seed, k);
        return b;
    endfunction

    // Drive one gated line, biphase coded, eight samples per bit.
    task automatic send_line(input logic [119:0] b, input int err_bit, input int nbits);
        line_en = 1'b1;
        for (int i = 0; i < nbits; i++) begin
            for (int s = 0; s < 8; s++) begin
                logic v;
                v = b[119 - i];
                din = (s < 4 || i == err_bit) ? v : ~v;
                @(negedge clk);
            end
        end
        line_en = 1'b0;
        din = 1'b0;
        repeat (20) @(negedge clk);
    endtask

    task automatic good_line(input int seed, input string tag);
        logic [119:0] b;
        logic [7:0] w5, w13, w14;
        int v0;
        b = build(seed);
        w5 = wval(seed, 5);
        w13 = wval(seed, 13);
        w14 = wval(seed, 14);
        v0 = vcnt;
        send_line(b, -1, 120);
        chk(vcnt == v0 + 1, {tag, " R8 strobe count"}, 128'(vcnt - v0), 128'd1);
        chk(words_o == b, {tag, " R2 words"}, 128'(words_o), 128'(b));
        chk(sound_o == w5[7:6], {tag, " R3 sound"}, 128'(sound_o), 128'(w5[7:6]));
        chk(cni_o == {w13[1:0], w14}, {tag, " R4 cni"}, 128'(cni_o), 128'({w13[1:0], w14}));
        chk(bphase_err_o == 1'b0, {tag, " R7 err clear"}, 128'(bphase_err_o), 128'd0);
        last_good = b;
    endtask

    task automatic rejected(input string tag, input bit exp_err);
        chk(words_o == last_good, {tag, " hold words"}, 128'(words_o), 128'(last_good));
        chk(bphase_err_o == exp_err, {tag, " err flag"}, 128'(bphase_err_o), 128'(exp_err));
    endtask

    initial begin
        int v0;
        logic [119:0] b;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(valid_o == 0 && bphase_err_o == 0, "R1 flags", 128'({valid_o, bphase_err_o}), 128'd0);
        chk(words_o == 0 && sound_o == 0 && cni_o == 0, "R1 fields", 128'(words_o), 128'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R2 R3 R4 R8: several clean lines
        for (int s = 1; s <= 6; s++) good_line(s * 11, "clean");

        // R5: corrupt sync word 1, then word 2
        b = build(77);
        b[119:112] = S1 ^ 8'h01;
        v0 = vcnt;
        send_line(b, -1, 120);
        chk(vcnt == v0, "R5 sync1 no strobe", 128'(vcnt - v0), 128'd0);
        rejected("R5 sync1", 1'b0);
        b = build(78);
        b[111:104] = S2 ^ 8'h80;
        v0 = vcnt;
        send_line(b, -1, 120);
        chk(vcnt == v0, "R5 sync2 no strobe", 128'(vcnt - v0), 128'd0);
        rejected("R5 sync2", 1'b0);

        // R6: one biphase violation swept across the line
        for (int j = 0; j < 127; j += 7) begin
            int jj;
            jj = (j > 119) ? 119 : j;
            v0 = vcnt;
            send_line(build(90 + j), jj, 120);
            chk(vcnt == v0, "R6 no strobe", 128'(jj), 128'(-1));
            rejected("R6 bit error", 1'b1);
        end

        // R7: next clean line clears the flag
        good_line(5, "R7 after error");

        // R9: gate drops mid-line
        v0 = vcnt;
        send_line(build(123), -1, 60);
        chk(vcnt == v0, "R9 early gate no strobe", 128'(vcnt - v0), 128'd0);
        rejected("R9 early gate", 1'b0);

        // R10: samples outside the gate
        v0 = vcnt;
        for (int i = 0; i < 600; i++) begin
            din = i[1] ^ i[3];
            @(negedge clk);
        end
        din = 1'b0;
        repeat (10) @(negedge clk);
        chk(vcnt == v0, "R10 gate low no strobe", 128'(vcnt - v0), 128'd0);
        rejected("R10 gate low", 1'b0);

        good_line(200, "final");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule